// File: doc/BRIEF.md
# Edge-Strobed Watchdog Timer

This block watches a strobe line driven by software and raises an alarm when the line goes quiet. A change of level in either direction counts as a sign of life. It clears the running count and timing starts again. If a whole timeout window passes with no change, the block drives its active-low status output low for a fixed number of microsecond ticks. It then reloads and starts timing again on its own. There is no way to switch the watchdog off.

The timeout is chosen from three levels on a select input. The select is sampled once, on the first microsecond tick after the power-on clear, and is ignored from then on. Timing is gated by a qualifier from the reset sequencers. While every reset output is still active, the counter stays at its reload value and the status output stays high. Counting starts once at least one reset has been released.

Top module: `edge_watchdog`

## Requirements
- R1: While the power-on clear is active and directly after it, `wd_status_n` is high.
- R2: The timeout select decodes as follows, using the level captured on the first tick after the clear. 2'b00 gives `T_SHORT` ticks, 2'b01 gives `T_MID` ticks, and 2'b10 or 2'b11 gives `T_LONG` ticks. Once armed with no strobe edge, `wd_status_n` falls exactly at the edge of the limit-th tick.
- R3: Any change of `tsel` after that capture has no effect on the timeout length.
- R4: While `rst_released` is low, `wd_status_n` stays high and no ticks are counted. Dropping `rst_released` during a pulse ends the pulse on the next clock.
- R5: A rising or a falling strobe edge, held for at least two clocks, restarts the timeout window. A strobe toggled more often than once per window never produces a pulse.
- R6: A timeout pulse lasts exactly `PULSE` ticks. Strobe edges during the pulse neither shorten nor extend it.
- R7: After a pulse ends, the counter restarts from its reload value. Without strobe edges, the next pulse begins after another full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| tick_us | input | 1 | One-cycle microsecond time base |
| strobe | input | 1 | Asynchronous activity strobe from software |
| tsel | input | 2 | Timeout select level, captured once |
| rst_released | input | 1 | High when at least one reset output is inactive |
| wd_status_n | output | 1 | Active-low timeout pulse |

## Verification
The hardest cases to reach are a strobe edge landing while a pulse is already under way, and a select change after capture. Neither changes the pulse, so both must be measured rather than merely observed. The bench toggles the strobe at the exact clock where it sees the fall, then measures the pulse width in ticks. It also changes `tsel` after capture and before arming, then measures the first window. All tick counts use a small configuration, and each select level, auto-restart and window boundary is swept.

// File: rtl/wd_pkg.sv
// Shared decode for the watchdog timeout select.
// Assumes the select pins were resolved to two bits by the pad logic.
package wd_pkg;
    typedef enum logic [1:0] {
        WIN_SHORT = 2'b00,
        WIN_MID   = 2'b01,
        WIN_LONG  = 2'b10
    } win_e;

    // Map raw select bits to a window class; 2'b11 is treated as the long window.
    function automatic win_e decode_sel(input logic [1:0] raw);
        if (raw[1])      return WIN_LONG;
        else if (raw[0]) return WIN_MID;
        else             return WIN_SHORT;
    endfunction
endpackage

// File: rtl/wd_strobe_sync.sv
// Brings the asynchronous strobe into the clock domain and flags every
// level change. Assumes each strobe level is held at least two clocks.
module wd_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic kick
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], strobe};
            last_q <= chain[STAGES-1];
        end
    end

    assign kick = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/wd_cfg_latch.sv
// Captures the timeout select on the first tick after clear and turns
// it into a tick limit. Later changes of the select are ignored.
module wd_cfg_latch
    import wd_pkg::*;
#(
    parameter int T_SHORT = 10000,
    parameter int T_MID   = 100000,
    parameter int T_LONG  = 1000000,
    parameter int CW      = $clog2(T_LONG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic [1:0]    tsel,
    output logic          cfg_valid,
    output logic [CW-1:0] limit
);
    win_e sel_q;

    // One-shot capture of the select level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            sel_q     <= WIN_SHORT;
        end else if (tick_us && !cfg_valid) begin
            cfg_valid <= 1'b1;
            sel_q     <= decode_sel(tsel);
        end
    end

    // Window length in ticks for the captured class.
    always_comb begin
        unique case (sel_q)
            WIN_MID:  limit = CW'(T_MID);
            WIN_LONG: limit = CW'(T_LONG);
            default:  limit = CW'(T_SHORT);
        endcase
    end

    assert_sel_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> $stable(sel_q));
endmodule

// File: rtl/wd_timer.sv
// Counts ticks since the last kick and emits a fixed-width low pulse on
// timeout, then restarts. Assumes limit >= 2 and PULSE >= 1.
module wd_timer #(
    parameter int CW    = 20,
    parameter int PULSE = 100,
    parameter int PW    = $clog2(PULSE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic          kick,
    input  logic          armed,
    input  logic [CW-1:0] limit,
    output logic          wd_status_n
);
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic          in_pulse;

    // Window counter and pulse sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            cnt      <= '0;
            pcnt     <= '0;
            in_pulse <= 1'b0;
        end else if (in_pulse) begin
            if (tick_us) begin
                if (pcnt == PW'(PULSE - 1)) begin
                    in_pulse <= 1'b0;
                    pcnt     <= '0;
                    cnt      <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end else if (kick) begin
            cnt <= '0;
        end else if (tick_us) begin
            if (cnt == limit - 1'b1) begin
                cnt      <= '0;
                in_pulse <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign wd_status_n = ~in_pulse;

    assert_quiet_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> wd_status_n);
    assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit || !armed);
    assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt < PW'(PULSE));
    assert_kick_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && kick && wd_status_n) |=> (cnt == '0));
endmodule

// File: rtl/edge_watchdog.sv
// Edge-strobed watchdog top: synchronizer, one-shot config capture and
// window timer. Assumes tick_us is a single-cycle pulse.
module edge_watchdog #(
    parameter int T_SHORT = 10000,
    parameter int T_MID   = 100000,
    parameter int T_LONG  = 1000000,
    parameter int PULSE   = 100,
    parameter int STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       strobe,
    input  logic [1:0] tsel,
    input  logic       rst_released,
    output logic       wd_status_n
);
    localparam int CW = $clog2(T_LONG + 1);

    logic          kick;
    logic          cfg_valid;
    logic [CW-1:0] limit;

    wd_strobe_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .kick(kick)
    );

    wd_cfg_latch #(.T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tsel(tsel),
        .cfg_valid(cfg_valid), .limit(limit)
    );

    wd_timer #(.CW(CW), .PULSE(PULSE)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .kick(kick),
        .armed(rst_released && cfg_valid), .limit(limit),
        .wd_status_n(wd_status_n)
    );

    assert_clear_high_R1: assert property (@(posedge clk)
        !rst_n |=> wd_status_n);
endmodule

// File: tb/tb_edge_watchdog.sv
module tb_edge_watchdog;
    localparam int TS = 5, TM = 8, TL = 12, PL = 3;

    logic clk = 0, rst_n = 0, tick_us = 0, strobe = 0, rst_released = 0;
    logic [1:0] tsel = 2'b00;
    logic wd_status_n;
    int checks = 0, failures = 0, tdiv = 0;
    bit done = 0, saw_low = 0;

    edge_watchdog #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL), .PULSE(PL)) dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .strobe(strobe),
        .tsel(tsel), .rst_released(rst_released), .wd_status_n(wd_status_n));

    always #4 clk = ~clk;

    // Tick every 8 clocks, changed on the falling edge.
    always @(negedge clk) begin
        tick_us <= (tdiv == 7);
        tdiv    <= (tdiv == 7) ? 0 : tdiv + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim(input logic [1:0] s);
        return s[1] ? TL : (s[0] ? TM : TS);
    endfunction

    // Wait n ticks, noting any low status; returns just after a tick edge.
    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick_us) c++;
            @(negedge clk);
            if (!wd_status_n) saw_low = 1;
        end
    endtask

    // Count ticks until status reaches the given level.
    task automatic measure(input logic lvl, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            if (tick_us) n++;
            @(negedge clk);
            if (wd_status_n == lvl || n > 40) break;
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 0; rst_released = 0; tsel = s;
        repeat (3) @(negedge clk);
        check("R1 during clear", wd_status_n, 1);
        rst_n = 1;
        wait_ticks(2);
        check("R1 after clear", wd_status_n, 1);
    endtask

    initial begin
        int n;
        // R2, R6, R7 sweep over every select code
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            rst_released = 1;
            measure(1'b0, n); check("R2 window", n, lim(2'(s)));
            measure(1'b1, n); check("R6 pulse width", n, PL);
            measure(1'b0, n); check("R7 restart window", n, lim(2'(s)));
            measure(1'b1, n);
        end
        // R3: select change after capture is ignored
        do_reset(2'b00);
        tsel = 2'b10;
        rst_released = 1;
        measure(1'b0, n); check("R3 late select", n, TS);
        // R4: pulse cut by dropping qualifier, then quiet while unarmed
        rst_released = 0;
        @(negedge clk); check("R4 pulse cut", wd_status_n, 1);
        wait_ticks(1);
        saw_low = 0;
        wait_ticks(3 * TL);
        check("R4 unarmed quiet", saw_low, 0);
        // R5: both edge directions restart the window
        do_reset(2'b01);
        rst_released = 1;
        saw_low = 0;
        for (int k = 0; k < 6; k++) begin
            wait_ticks(TM - 2);
            strobe = ~strobe;
        end
        check("R5 no pulse with kicks", saw_low, 0);
        measure(1'b0, n); check("R5 window after last edge", n, TM);
        // R6: strobe edge during the pulse does not change it
        strobe = ~strobe;
        measure(1'b1, n); check("R6 kick during pulse", n, PL);
        measure(1'b0, n); check("R7 window after kicked pulse", n, TM);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule